// File: doc/BRIEF.md
# Special-Purpose Register Access Decoder

This block answers the move-to and move-from special-register requests of a 32-bit processor core. Each request presents a 16-bit register number: a 5-bit group in the top bits and an 11-bit index below it. A write is captured on the clock edge where the write strobe is high. A read is purely combinational from the address, so the core can return the value in the same cycle it asks.

The block holds four exception-handling registers: the vector base, the saved exception PC, the faulting effective address and the saved status word. It holds a 64-bit multiply-accumulate register that is reached as two 32-bit halves. It holds a banked shadow copy of the general registers, addressed by a flat offset. It also supplies a set of read-only identity and configuration words and the core-number and core-count words, all fixed by parameters. A read of any address the block does not implement gives back the destination value the core passed in with the request. A write to such an address is dropped.

Top module: `spr_access_unit`

## Requirements
- R1: The register number is group * 2048 + index (group in spr_addr[15:11], index in spr_addr[10:0]). In group 0, index 11 is the vector base, 32 the exception PC, 48 the effective address and 64 the exception status. Each reads back the last value written to it.
- R2: While rst_n is low, every writable register reads zero: the four exception registers, both accumulator halves and all shadow entries.
- R3: Group 0 indices 0, 1, 2, 3, 4, 9 and 10 read the parameters ID_VERSION, ID_UNITS, ID_CORE_CFG, ID_DXLAT_CFG, ID_IXLAT_CFG, ID_VERSION2 and ID_ARCH respectively. A write to any of them changes nothing that can be read.
- R4: Group 0 index 1024 + k, for k from 0 to SHADOW_BANKS*SHADOW_REGS-1, addresses shadow entry k: bank k/32 and register k%32 with the default 32 registers per bank. Every entry stores its own value.
- R5: Group 5 index 1 reads and writes accumulator bits 31:0, and group 5 index 2 reads and writes bits 63:32. Writing one half leaves the other half as it was.
- R6: A read of an address that matches no implemented register returns rd_in unchanged in the same cycle.
- R7: Group 0 index 128 reads the parameter CORE_ID, and index 129 reads the parameter NUM_CORES. Writes to them are ignored.
- R8: A write to an unimplemented address changes no register.
- R9: A write with spr_we high is visible on spr_rdata from the first clock edge after it. Until that edge the read still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spr_addr | input | 16 | Register number: group in bits 15:11, index in bits 10:0 |
| spr_we | input | 1 | Write strobe for the addressed register |
| spr_wdata | input | 32 | Write data |
| rd_in | input | 32 | Core's prior destination value, returned on an unmatched read |
| spr_rdata | output | 32 | Combinational read data for spr_addr |

## Verification
A corrupted register shows up on spr_rdata as soon as its address is presented, because reads are combinational. The bench reads after every write and compares every applied vector with its model, so a bad capture is seen on the next access to that address. A write that reaches the wrong register, such as the other accumulator half, a neighbouring shadow entry or a decoded-away address, shows as a miscompare at the first later read of the victim. Random phases revisit the same small address set often, so that read follows within a few dozen cycles.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int ADDR_W  = 16;
    localparam int GROUP_W = 5;
    localparam int INDEX_W = 11;

    localparam logic [GROUP_W-1:0] GRP_SYS = 5'd0;
    localparam logic [GROUP_W-1:0] GRP_MAC = 5'd5;

    localparam logic [INDEX_W-1:0] IX_VERSION  = 11'd0;
    localparam logic [INDEX_W-1:0] IX_UNITS    = 11'd1;
    localparam logic [INDEX_W-1:0] IX_CORECFG  = 11'd2;
    localparam logic [INDEX_W-1:0] IX_DXLAT    = 11'd3;
    localparam logic [INDEX_W-1:0] IX_IXLAT    = 11'd4;
    localparam logic [INDEX_W-1:0] IX_VERSION2 = 11'd9;
    localparam logic [INDEX_W-1:0] IX_ARCH     = 11'd10;
    localparam logic [INDEX_W-1:0] IX_VBASE    = 11'd11;
    localparam logic [INDEX_W-1:0] IX_EPC      = 11'd32;
    localparam logic [INDEX_W-1:0] IX_EEA      = 11'd48;
    localparam logic [INDEX_W-1:0] IX_ESTAT    = 11'd64;
    localparam logic [INDEX_W-1:0] IX_COREID   = 11'd128;
    localparam logic [INDEX_W-1:0] IX_NCORES   = 11'd129;
    localparam logic [INDEX_W-1:0] IX_ACC_LO   = 11'd1;
    localparam logic [INDEX_W-1:0] IX_ACC_HI   = 11'd2;

    localparam int EXC_REGS = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CONST,
        SEL_EXC,
        SEL_SHADOW,
        SEL_ACC_LO,
        SEL_ACC_HI
    } spr_sel_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_WORDS = 512,
    parameter int SH_AW = 9,
    parameter logic [DATA_W-1:0] CORE_ID = '0,
    parameter logic [DATA_W-1:0] NUM_CORES = 1,
    parameter logic [DATA_W-1:0] ID_VERSION = '0,
    parameter logic [DATA_W-1:0] ID_UNITS = '0,
    parameter logic [DATA_W-1:0] ID_CORE_CFG = '0,
    parameter logic [DATA_W-1:0] ID_DXLAT_CFG = '0,
    parameter logic [DATA_W-1:0] ID_IXLAT_CFG = '0,
    parameter logic [DATA_W-1:0] ID_VERSION2 = '0,
    parameter logic [DATA_W-1:0] ID_ARCH = '0
) (
    input  logic [ADDR_W-1:0]   addr,
    output spr_sel_e            sel,
    output logic [EXC_REGS-1:0] exc_hit,
    output logic [SH_AW-1:0]    sh_off,
    output logic [DATA_W-1:0]   const_val
);
    localparam logic [INDEX_W-1:0] SH_LIMIT = INDEX_W'(SH_WORDS);

    logic [GROUP_W-1:0] grp;
    logic [INDEX_W-1:0] idx;
    logic [INDEX_W-1:0] sh_rel;
    logic               sh_in_range;

    assign grp = addr[ADDR_W-1:INDEX_W];
    assign idx = addr[INDEX_W-1:0];
    assign sh_rel = {1'b0, idx[INDEX_W-2:0]};
    assign sh_in_range = idx[INDEX_W-1] && (sh_rel < SH_LIMIT);
    assign sh_off = sh_rel[SH_AW-1:0];

    always_comb begin
        sel = SEL_NONE;
        exc_hit = '0;
        const_val = '0;
        if (grp == GRP_SYS) begin
            unique case (idx)
                IX_VERSION:  begin sel = SEL_CONST; const_val = ID_VERSION;   end
                IX_UNITS:    begin sel = SEL_CONST; const_val = ID_UNITS;     end
                IX_CORECFG:  begin sel = SEL_CONST; const_val = ID_CORE_CFG;  end
                IX_DXLAT:    begin sel = SEL_CONST; const_val = ID_DXLAT_CFG; end
                IX_IXLAT:    begin sel = SEL_CONST; const_val = ID_IXLAT_CFG; end
                IX_VERSION2: begin sel = SEL_CONST; const_val = ID_VERSION2;  end
                IX_ARCH:     begin sel = SEL_CONST; const_val = ID_ARCH;      end
                IX_COREID:   begin sel = SEL_CONST; const_val = CORE_ID;      end
                IX_NCORES:   begin sel = SEL_CONST; const_val = NUM_CORES;    end
                IX_VBASE:    begin sel = SEL_EXC; exc_hit = 4'b0001; end
                IX_EPC:      begin sel = SEL_EXC; exc_hit = 4'b0010; end
                IX_EEA:      begin sel = SEL_EXC; exc_hit = 4'b0100; end
                IX_ESTAT:    begin sel = SEL_EXC; exc_hit = 4'b1000; end
                default: begin
                    if (sh_in_range) sel = SEL_SHADOW;
                end
            endcase
        end else if (grp == GRP_MAC) begin
            if (idx == IX_ACC_LO) sel = SEL_ACC_LO;
            else if (idx == IX_ACC_HI) sel = SEL_ACC_HI;
        end
    end
endmodule

// File: rtl/spr_exc_regs.sv
module spr_exc_regs
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [EXC_REGS-1:0] hit,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] q [EXC_REGS];

    for (genvar k = 0; k < EXC_REGS; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[k] <= '0;
            else if (we && hit[k]) q[k] <= wdata;
        end

        // R9
        exc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && hit[k]) |=> (q[k] == $past(wdata)));

        // R2
        exc_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (q[k] == '0));
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < EXC_REGS; k++) begin
            if (hit[k]) rdata = q[k];
        end
    end

    // R1
    exc_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/spr_mac_acc.sv
module spr_mac_acc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi
);
    localparam int ACC_W = 2 * DATA_W;

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            if (we_lo) acc[DATA_W-1:0] <= wdata;
            if (we_hi) acc[ACC_W-1:DATA_W] <= wdata;
        end
    end

    assign lo = acc[DATA_W-1:0];
    assign hi = acc[ACC_W-1:DATA_W];

    // R5
    acc_hi_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !we_hi) |=> (hi == $past(hi)));

    // R5
    acc_lo_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !we_lo) |=> (lo == $past(lo)));
endmodule

// File: rtl/spr_shadow_file.sv
module spr_shadow_file #(
    parameter int DATA_W = 32,
    parameter int BANKS = 16,
    parameter int REGS = 32,
    localparam int WORDS = BANKS * REGS,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[off] <= wdata;
        end
    end

    assign rdata = mem[off];

    // R4
    shadow_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(off)] == $past(wdata)));
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SHADOW_BANKS = 16,
    parameter int SHADOW_REGS = 32,
    parameter logic [DATA_W-1:0] CORE_ID = 32'd0,
    parameter logic [DATA_W-1:0] NUM_CORES = 32'd1,
    parameter logic [DATA_W-1:0] ID_VERSION = 32'h1200_0001,
    parameter logic [DATA_W-1:0] ID_UNITS = 32'h0000_0701,
    parameter logic [DATA_W-1:0] ID_CORE_CFG = 32'h0000_0020,
    parameter logic [DATA_W-1:0] ID_DXLAT_CFG = 32'h0000_0018,
    parameter logic [DATA_W-1:0] ID_IXLAT_CFG = 32'h0000_0019,
    parameter logic [DATA_W-1:0] ID_VERSION2 = 32'h0100_0000,
    parameter logic [DATA_W-1:0] ID_ARCH = 32'h0001_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       spr_addr,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    input  logic [DATA_W-1:0] rd_in,
    output logic [DATA_W-1:0] spr_rdata
);
    localparam int SH_WORDS = SHADOW_BANKS * SHADOW_REGS;
    localparam int SH_AW = $clog2(SH_WORDS);

    spr_sel_e            sel;
    logic [EXC_REGS-1:0] exc_hit;
    logic [SH_AW-1:0]    sh_off;
    logic [DATA_W-1:0]   const_val;
    logic [DATA_W-1:0]   exc_q;
    logic [DATA_W-1:0]   sh_q;
    logic [DATA_W-1:0]   acc_lo;
    logic [DATA_W-1:0]   acc_hi;

    spr_decode #(
        .DATA_W(DATA_W), .SH_WORDS(SH_WORDS), .SH_AW(SH_AW),
        .CORE_ID(CORE_ID), .NUM_CORES(NUM_CORES),
        .ID_VERSION(ID_VERSION), .ID_UNITS(ID_UNITS),
        .ID_CORE_CFG(ID_CORE_CFG), .ID_DXLAT_CFG(ID_DXLAT_CFG),
        .ID_IXLAT_CFG(ID_IXLAT_CFG), .ID_VERSION2(ID_VERSION2),
        .ID_ARCH(ID_ARCH)
    ) u_decode (
        .addr(spr_addr), .sel(sel), .exc_hit(exc_hit),
        .sh_off(sh_off), .const_val(const_val)
    );

    spr_exc_regs #(.DATA_W(DATA_W)) u_exc (
        .clk(clk), .rst_n(rst_n), .we(spr_we), .hit(exc_hit),
        .wdata(spr_wdata), .rdata(exc_q)
    );

    spr_mac_acc #(.DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .we_lo(spr_we && (sel == SEL_ACC_LO)),
        .we_hi(spr_we && (sel == SEL_ACC_HI)),
        .wdata(spr_wdata), .lo(acc_lo), .hi(acc_hi)
    );

    spr_shadow_file #(
        .DATA_W(DATA_W), .BANKS(SHADOW_BANKS), .REGS(SHADOW_REGS)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .we(spr_we && (sel == SEL_SHADOW)),
        .off(sh_off), .wdata(spr_wdata), .rdata(sh_q)
    );

    always_comb begin
        unique case (sel)
            SEL_CONST:  spr_rdata = const_val;
            SEL_EXC:    spr_rdata = exc_q;
            SEL_SHADOW: spr_rdata = sh_q;
            SEL_ACC_LO: spr_rdata = acc_lo;
            SEL_ACC_HI: spr_rdata = acc_hi;
            default:    spr_rdata = rd_in;
        endcase
    end

    // R6
    foreign_group_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((spr_addr[15:11] != 5'd0) && (spr_addr[15:11] != 5'd5)) |-> (spr_rdata == rd_in));

    // R3
    version_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_addr == 16'd0) |-> (spr_rdata == ID_VERSION));

    // R7
    core_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_addr == 16'd129) |-> (spr_rdata == NUM_CORES));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && (spr_addr[15:11] != 5'd0) && (spr_addr[15:11] != 5'd5))
        |=> ($stable(acc_lo) && $stable(acc_hi) && $stable(u_exc.q[0]) &&
             $stable(u_exc.q[1]) && $stable(u_exc.q[2]) && $stable(u_exc.q[3])));
endmodule

// File: tb/sim_spr_access_unit.sv
module sim_spr_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 512;
    localparam logic [31:0] P_CORE = 32'd3;
    localparam logic [31:0] P_NCORE = 32'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] spr_addr = '0;
    logic        spr_we = 1'b0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] rd_in = '0;
    logic [31:0] spr_rdata;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_exc [4];
    logic [63:0] m_acc;
    logic [31:0] m_sh [WORDS];
    logic [31:0] m_const [11];

    spr_access_unit #(.CORE_ID(P_CORE), .NUM_CORES(P_NCORE)) u0 (
        .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .rd_in(rd_in), .spr_rdata(spr_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic model_clear();
        for (int i = 0; i < 4; i++) m_exc[i] = '0;
        m_acc = '0;
        for (int i = 0; i < WORDS; i++) m_sh[i] = '0;
    endtask

    function automatic int exc_slot(int idx);
        case (idx)
            11: return 0;
            32: return 1;
            48: return 2;
            64: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [15:0] a, logic [31:0] pass);
        int g = int'(a[15:11]);
        int ix = int'(a[10:0]);
        if (g == 0) begin
            if (ix <= 10 && (ix <= 4 || ix >= 9)) return m_const[ix];
            if (exc_slot(ix) >= 0) return m_exc[exc_slot(ix)];
            if (ix == 128) return P_CORE;
            if (ix == 129) return P_NCORE;
            if (ix >= 1024 && ix < 1024 + WORDS) return m_sh[ix - 1024];
        end else if (g == 5) begin
            if (ix == 1) return m_acc[31:0];
            if (ix == 2) return m_acc[63:32];
        end
        return pass;
    endfunction

    task automatic model_write(logic [15:0] a, logic [31:0] d);
        int g = int'(a[15:11]);
        int ix = int'(a[10:0]);
        if (g == 0) begin
            if (exc_slot(ix) >= 0) m_exc[exc_slot(ix)] = d;
            else if (ix >= 1024 && ix < 1024 + WORDS) m_sh[ix - 1024] = d;
        end else if (g == 5) begin
            if (ix == 1) m_acc[31:0] = d;
            else if (ix == 2) m_acc[63:32] = d;
        end
    endtask

    function automatic string tag_of(logic [15:0] a);
        int g = int'(a[15:11]);
        int ix = int'(a[10:0]);
        if (g == 0 && ix <= 10 && (ix <= 4 || ix >= 9)) return "R3";
        if (g == 0 && exc_slot(ix) >= 0) return "R1";
        if (g == 0 && (ix == 128 || ix == 129)) return "R7";
        if (g == 0 && ix >= 1024 && ix < 1024 + WORDS) return "R4";
        if (g == 5 && (ix == 1 || ix == 2)) return "R5";
        return "R6";
    endfunction

    task automatic apply(logic [15:0] a, logic we, logic [31:0] d, logic [31:0] pass, string tag);
        logic [31:0] exp;
        @(negedge clk);
        spr_addr = a;
        spr_we = we;
        spr_wdata = d;
        rd_in = pass;
        #1;
        exp = model_read(a, pass);
        vectors++;
        if (spr_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, spr_rdata, exp);
        end
        @(posedge clk);
        if (we && rst_n) model_write(a, d);
    endtask

    function automatic logic [15:0] pick_addr(int r);
        logic [15:0] list [14];
        list[0] = 16'd11;   list[1] = 16'd32;    list[2] = 16'd48;
        list[3] = 16'd64;   list[4] = 16'h2801;  list[5] = 16'h2802;
        list[6] = 16'd0;    list[7] = 16'd10;    list[8] = 16'd129;
        list[9] = 16'd1024; list[10] = 16'd1535; list[11] = 16'd1536;
        list[12] = 16'h2803; list[13] = 16'd12;
        if (r % 3 == 0) return 16'(1024 + (r / 3) % 24);
        return list[(r / 3) % 14];
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        m_const[0] = 32'h1200_0001; m_const[1] = 32'h0000_0701;
        m_const[2] = 32'h0000_0020; m_const[3] = 32'h0000_0018;
        m_const[4] = 32'h0000_0019; m_const[9] = 32'h0100_0000;
        m_const[10] = 32'h0001_0100;
        for (int i = 5; i < 9; i++) m_const[i] = '0;
        model_clear();

        // R2: values during reset
        apply(16'd11, 1'b1, 32'hDEAD_BEEF, 32'h0, "R2");
        apply(16'd11, 1'b0, 32'h0, 32'h0, "R2");
        apply(16'h2802, 1'b0, 32'h0, 32'h0, "R2");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: exception registers, read follows write
        apply(16'd11, 1'b1, 32'h0000_2000, 32'h1, "R9");
        apply(16'd11, 1'b0, 32'h0, 32'h1, "R1");
        apply(16'd32, 1'b1, 32'h1111_2222, 32'h0, "R1");
        apply(16'd48, 1'b1, 32'h3333_4444, 32'h0, "R1");
        apply(16'd64, 1'b1, 32'h5555_6666, 32'h0, "R1");
        apply(16'd32, 1'b0, 32'h0, 32'h0, "R1");
        apply(16'd48, 1'b0, 32'h0, 32'h0, "R1");
        apply(16'd64, 1'b0, 32'h0, 32'h0, "R1");

        // R3 / R7: constants, writes ignored
        apply(16'd0, 1'b1, 32'hFFFF_FFFF, 32'h0, "R3");
        apply(16'd0, 1'b0, 32'h0, 32'h0, "R3");
        apply(16'd9, 1'b1, 32'h1234_5678, 32'h0, "R3");
        apply(16'd9, 1'b0, 32'h0, 32'h0, "R3");
        apply(16'd128, 1'b1, 32'h77, 32'h0, "R7");
        apply(16'd128, 1'b0, 32'h0, 32'h0, "R7");
        apply(16'd129, 1'b0, 32'h0, 32'h0, "R7");

        // R5: accumulator halves
        apply(16'h2801, 1'b1, 32'hAAAA_0001, 32'h0, "R5");
        apply(16'h2802, 1'b1, 32'hBBBB_0002, 32'h0, "R5");
        apply(16'h2801, 1'b1, 32'hCCCC_0003, 32'h0, "R5");
        apply(16'h2802, 1'b0, 32'h0, 32'h0, "R5");
        apply(16'h2801, 1'b0, 32'h0, 32'h0, "R5");

        // R4: shadow file edges, bank boundary
        apply(16'd1024, 1'b1, 32'h0BAD_0000, 32'h0, "R4");
        apply(16'd1055, 1'b1, 32'h0BAD_001F, 32'h0, "R4");
        apply(16'd1056, 1'b1, 32'h0BAD_0020, 32'h0, "R4");
        apply(16'd1535, 1'b1, 32'h0BAD_01FF, 32'h0, "R4");
        apply(16'd1024, 1'b0, 32'h0, 32'h0, "R4");
        apply(16'd1055, 1'b0, 32'h0, 32'h0, "R4");
        apply(16'd1056, 1'b0, 32'h0, 32'h0, "R4");
        apply(16'd1535, 1'b0, 32'h0, 32'h0, "R4");

        // R6 / R8: unmatched addresses
        apply(16'd1536, 1'b1, 32'h9999_9999, 32'hCAFE_0001, "R8");
        apply(16'd1536, 1'b0, 32'h0, 32'hCAFE_0002, "R6");
        apply(16'h2803, 1'b1, 32'h9999_9999, 32'hCAFE_0003, "R8");
        apply(16'h0800 | 16'd11, 1'b1, 32'h9999_9999, 32'hCAFE_0004, "R8");
        apply(16'd12, 1'b0, 32'h0, 32'hCAFE_0005, "R6");
        apply(16'hF801, 1'b0, 32'h0, 32'h1357_9BDF, "R6");
        apply(16'd11, 1'b0, 32'h0, 32'h0, "R8");
        apply(16'h2801, 1'b0, 32'h0, 32'h0, "R8");
        apply(16'h2802, 1'b0, 32'h0, 32'h0, "R8");

        // random mix over the interesting set
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] a = pick_addr(int'($urandom % 1000));
            logic w = ($urandom % 2) == 1;
            apply(a, w, $urandom, $urandom, tag_of(a));
        end

        // R2: reset after traffic
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        apply(16'd64, 1'b0, 32'h0, 32'h0, "R2");
        apply(16'h2801, 1'b0, 32'h0, 32'h0, "R2");
        apply(16'd1056, 1'b0, 32'h0, 32'h0, "R2");
        @(negedge clk);
        rst_n = 1'b1;
        apply(16'd1535, 1'b0, 32'h0, 32'h0, "R2");
        apply(16'd32, 1'b0, 32'h0, 32'h0, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule